// File: doc/BRIEF.md
# Cartridge Bus Wait-State Controller

This block works out how many bus cycles each read on an external cartridge bus costs. The bus has three ROM windows and one SRAM window. A 16-bit control register sets the timing. Each ROM window gets a first-access (non-sequential) wait and a burst (sequential) wait from that register. The SRAM window gets a single wait.

For each request the block takes an address and an access size. It finds the window from three address bits. For a ROM read it then checks whether the address follows straight on from the last ROM read. One cycle later it returns the cost and a one-cycle done strobe. Writing the control register also clears the stored ROM address, so the first ROM read after a write is always treated as non-sequential. The block moves no data; it only reports the cost.

Top module: `cart_wait_ctrl`

## Requirements
- R1: While reset is held and after it is released, `cost_done` is 0 and `cost_cycles` is 0. The control register resets to 0 and the stored ROM address resets to 0.
- R2: The window comes from `req_addr[27:25]`: 100, 101 and 110 select ROM windows 0, 1 and 2, and 111 selects SRAM. Any other value is unmapped and costs 0 cycles.
- R3: The non-sequential wait of ROM windows 0, 1 and 2 comes from control bits [3:2], [6:5] and [9:8]. Codes 0, 1, 2 and 3 give 4, 3, 2 and 8 cycles.
- R4: The sequential wait of ROM windows 0, 1 and 2 comes from control bits 4, 7 and 10. A set bit gives 1 cycle. A clear bit gives 2, 4 or 8 cycles for windows 0, 1 and 2.
- R5: A ROM read is sequential only when its address equals the stored address plus the access step. Size code 0 is a byte (step 1), 1 a halfword (step 2), 2 a word (step 4). Code 3 behaves as a word.
- R6: A word-sized ROM read (size 2 or 3) costs 3 cycles more than a byte or halfword read in the same window and sequential state.
- R7: Every ROM read stores its address as the new stored address, whether or not it was sequential. SRAM and unmapped requests leave the stored address unchanged.
- R8: A write to the control register sets the stored ROM address to 0.
- R9: An SRAM request costs the wait set by control bits [1:0] (codes 0 to 3 give 4, 3, 2, 8). The size and the ROM history do not affect it.
- R10: `cost_done` pulses for exactly one cycle, on the clock after an accepted request. `cost_cycles` changes only on that clock and then holds its value.
- R11: When a control write and a ROM read happen in the same cycle, the read is costed with the old settings and the old stored address. The stored address then becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write value |
| req_valid | input | 1 | Read request present this cycle |
| req_size | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 word) |
| req_addr | input | 32 | Request byte address |
| cost_done | output | 1 | One-cycle pulse: cost is ready |
| cost_cycles | output | 4 | Cycle cost of the last request |

## Verification
A control write and a ROM read can arrive in the same cycle. Both then act on the stored address: the write clears it and the read would replace it. The bench drives both in one cycle, choosing a read that is sequential to the previous one under the old settings.

It expects two things. The reported cost must be the sequential cost under the old settings. The next contiguous read must then be costed as non-sequential under the new settings, which shows that the clear won over the update.

// File: rtl/cwc_pkg.sv
package cwc_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  // Wait code to cycle count: 0->4, 1->3, 2->2, 3->8
  function automatic logic [3:0] code_to_wait(input logic [1:0] code);
    logic [3:0] w;
    case (code)
      2'd0:    w = 4'd4;
      2'd1:    w = 4'd3;
      2'd2:    w = 4'd2;
      default: w = 4'd8;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/cwc_cfg_reg.sv
module cwc_cfg_reg #(
  parameter int CFG_W   = 16,
  parameter int NUM_WIN = 3,
  parameter int COST_W  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [CFG_W-1:0]               cfg_wdata,
  output logic [NUM_WIN-1:0][COST_W-1:0] ns_wait,
  output logic [NUM_WIN-1:0][COST_W-1:0] sq_wait,
  output logic [COST_W-1:0]              sram_wait
);
  import cwc_pkg::*;

  localparam int USED_W = 2 + 3 * NUM_WIN;

  logic [USED_W-1:0] ctrl_q, ctrl_d;
  logic              unused_hi;

  assign unused_hi = ^cfg_wdata[CFG_W-1:USED_W];

  always_comb begin
    ctrl_d = ctrl_q;
    if (cfg_we) ctrl_d = cfg_wdata[USED_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign sram_wait = COST_W'(code_to_wait(ctrl_q[1:0]));

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam int BASE = 2 + 3 * w;
    assign ns_wait[w] = COST_W'(code_to_wait(ctrl_q[BASE +: 2]));
    assign sq_wait[w] = ctrl_q[BASE + 2] ? COST_W'(1) : COST_W'(2 << w);
  end

  // R8
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> ctrl_q == $past(cfg_wdata[USED_W-1:0]));

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(ctrl_q));

endmodule

// File: rtl/cwc_seq_track.sv
module cwc_seq_track #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              is_seq
);
  import cwc_pkg::*;

  logic [ADDR_W-1:0] hist_q, hist_d, step;

  always_comb begin
    case (acc_size_e'(size))
      SZ_BYTE: step = ADDR_W'(1);
      SZ_HALF: step = ADDR_W'(2);
      default: step = ADDR_W'(4);
    endcase
  end

  assign is_seq = (addr == hist_q + step);

  always_comb begin
    hist_d = hist_q;
    if (clr)      hist_d = '0;
    else if (upd) hist_d = addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  // R8
  hist_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> hist_q == '0);

  // R7
  hist_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clr) |=> hist_q == $past(addr));

  // R7
  hist_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !clr) |=> $stable(hist_q));

endmodule

// File: rtl/cart_wait_ctrl.sv
module cart_wait_ctrl #(
  parameter int ADDR_W  = 32,
  parameter int CFG_W   = 16,
  parameter int COST_W  = 4,
  parameter int WIN_LSB = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              cost_done,
  output logic [COST_W-1:0] cost_cycles
);
  localparam int NUM_WIN  = 3;
  localparam int WORD_ADD = 3;

  logic [NUM_WIN-1:0][COST_W-1:0] ns_wait, sq_wait;
  logic [COST_W-1:0]              sram_wait;
  logic [2:0]                     sel;
  logic                           rom_hit, sram_hit, is_seq, is_word;
  logic [COST_W-1:0]              base_cost, cost_d, cost_q;
  logic                           done_d, done_q;

  cwc_cfg_reg #(.CFG_W(CFG_W), .NUM_WIN(NUM_WIN), .COST_W(COST_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ns_wait(ns_wait), .sq_wait(sq_wait), .sram_wait(sram_wait)
  );

  assign sel      = req_addr[WIN_LSB +: 3];
  assign rom_hit  = sel[2] && (sel[1:0] != 2'b11);
  assign sram_hit = (sel == 3'b111);
  assign is_word  = req_size[1];

  cwc_seq_track #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(cfg_we),
    .upd(req_valid && rom_hit), .addr(req_addr), .size(req_size),
    .is_seq(is_seq)
  );

  always_comb begin
    base_cost = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (rom_hit && sel[1:0] == 2'(w))
        base_cost = is_seq ? sq_wait[w] : ns_wait[w];
    end
  end

  always_comb begin
    if (rom_hit)       cost_d = base_cost + (is_word ? COST_W'(WORD_ADD) : '0);
    else if (sram_hit) cost_d = sram_wait;
    else               cost_d = '0;
    done_d = req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cost_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (req_valid) cost_q <= cost_d;
    end
  end

  assign cost_done   = done_q;
  assign cost_cycles = cost_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> cost_done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !cost_done && $stable(cost_cycles));

  // R6
  rom_cost_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rom_hit) |=> cost_cycles >= COST_W'(1) && cost_cycles <= COST_W'(11));

  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rom_hit && !sram_hit) |=> cost_cycles == '0);

endmodule

// File: tb/cart_wait_ctrl_test.sv
module cart_wait_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [15:0] cfg_wdata;
  logic        req_valid;
  logic [1:0]  req_size;
  logic [31:0] req_addr;
  logic        cost_done;
  logic [3:0]  cost_cycles;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cart_wait_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_size(req_size), .req_addr(req_addr),
    .cost_done(cost_done), .cost_cycles(cost_cycles)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  size;
    logic [3:0]  cost;
  } vec_t;

  // Run with control 0x179: SRAM 3, w0 ns2/sq1, w1 ns8/sq4, w2 ns3/sq8
  localparam vec_t VEC [16] = '{
    '{32'h0800_0000, 2'd2, 4'd5},   // R3 R6 nonseq word
    '{32'h0800_0004, 2'd2, 4'd4},   // R4 R6 seq word
    '{32'h0800_0006, 2'd1, 4'd1},   // R5 seq half
    '{32'h0800_0007, 2'd0, 4'd1},   // R5 seq byte
    '{32'h0800_0009, 2'd0, 4'd2},   // R5 gap -> nonseq
    '{32'h0A00_0000, 2'd1, 4'd8},   // R3 w1 nonseq
    '{32'h0A00_0002, 2'd1, 4'd4},   // R4 w1 slow seq
    '{32'h0A00_0004, 2'd2, 4'd11},  // R5 step mismatch
    '{32'h0E00_0010, 2'd0, 4'd3},   // R9 SRAM
    '{32'h0A00_0008, 2'd2, 4'd7},   // R7 SRAM kept history
    '{32'h0C00_0000, 2'd0, 4'd3},   // R3 w2 nonseq
    '{32'h0C00_0001, 2'd0, 4'd8},   // R4 w2 slow seq
    '{32'h0C00_0003, 2'd1, 4'd8},   // R5 half seq
    '{32'h0000_0010, 2'd0, 4'd0},   // R2 unmapped
    '{32'h0C00_0007, 2'd2, 4'd11},  // R7 unmapped kept history
    '{32'h0C00_000B, 2'd3, 4'd11}   // R5 R6 size 3 as word
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic [1:0] s,
                       input logic [3:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = s;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " done"}, {31'd0, cost_done}, 32'd1);
    check({tag, " cost"}, {28'd0, cost_cycles}, {28'd0, exp});
  endtask

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    req_valid = 1'b0; req_size = '0; req_addr = '0;
    repeat (3) @(negedge clk);
    check("R1 done in reset", {31'd0, cost_done}, 32'd0);
    check("R1 cost in reset", {28'd0, cost_cycles}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after reset", {31'd0, cost_done}, 32'd0);

    // Default control 0: every window 4 non-seq, slow seq 2/4/8, SRAM 4
    issue(32'h0800_0000, 2'd0, 4'd4, "R1 R3 w0 default nonseq");
    issue(32'h0800_0001, 2'd0, 4'd2, "R4 w0 default seq");
    issue(32'h0800_0002, 2'd2, 4'd7, "R5 R6 word after byte nonseq");
    issue(32'h0A00_0000, 2'd0, 4'd4, "R2 w1 default nonseq");
    issue(32'h0A00_0001, 2'd0, 4'd4, "R4 w1 default seq");
    issue(32'h0D00_0000, 2'd0, 4'd4, "R2 w2 via bit 24 set");
    issue(32'h0D00_0001, 2'd0, 4'd8, "R4 w2 default seq");
    issue(32'h0F00_0000, 2'd2, 4'd4, "R9 SRAM default word");

    // R10: idle cycle drops done and holds the cost
    @(negedge clk);
    check("R10 done low when idle", {31'd0, cost_done}, 32'd0);
    check("R10 cost held when idle", {28'd0, cost_cycles}, 32'd4);

    // R8: control write makes the next contiguous read non-sequential
    write_cfg(16'h0179);
    foreach (VEC[i])
      issue(VEC[i].addr, VEC[i].size, VEC[i].cost, $sformatf("table %0d", i));

    issue(32'h0800_0100, 2'd0, 4'd2, "R3 w0 fresh nonseq");
    write_cfg(16'h0179);
    issue(32'h0800_0101, 2'd0, 4'd2, "R8 write cleared history");

    // R11: control write and a sequential ROM read in one cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 16'h0000;
    req_valid = 1'b1; req_addr = 32'h0800_0102; req_size = 2'd0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R11 collision done", {31'd0, cost_done}, 32'd1);
    check("R11 collision old settings seq", {28'd0, cost_cycles}, 32'd1);
    issue(32'h0800_0103, 2'd0, 4'd4, "R11 clear wins, new settings");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule